// File: doc/BRIEF.md
# DMA Page Address Extender

This block holds a bank of page bytes for each of four DMA channels and uses them to widen a channel's 16-bit current address into a 31-bit physical memory address. Software reaches the page bytes through a byte-wide register port. A three-bit port offset selects the channel through a fixed, scrambled map that has holes in it, and a bank select chooses between the low page byte and the high page byte. The high bank can be left out at build time. When it is left out, it neither stores writes nor returns data.

On the transfer side, a request carries a channel number, the channel's current address, a position within the block, a length, the direction bit taken from that channel's mode setting, and one word of data lanes. The request is a valid/ready stream. Each accepted request produces one registered result one cycle later. For upward transfers the result is the physical base plus the position. For downward transfers it is the base minus the position minus the length, and the data lanes come back in reverse byte order. The result stream is also valid/ready. While the result is held, the request side is not ready. A result stays unchanged until it is taken.

Top module: `dma_page_ext`

## Requirements
- R1: After reset every low and high page byte reads back as zero and `out_valid` is low.
- R2: Port offsets 7, 3, 1 and 2 select channels 0, 1, 2 and 3 respectively. `io_bank`=0 addresses the low page byte and `io_bank`=1 the high page byte. A write with `io_wr` high stores `io_wdata` at the clock edge. `io_rdata` returns the addressed byte combinationally and shows the new value from the cycle after the write.
- R3: Offsets 0, 4, 5 and 6 are holes. A write to a hole changes no page byte, and a read from a hole gives zero.
- R4: With `req_dir`=0 the result address is {high page bits 6..0, low page, `req_cur`} + `req_pos`, modulo 2^31. Bit 7 of the high page is stored and read back but never reaches the address.
- R5: With `req_dir`=1 the result address is {high page bits 6..0, low page, `req_cur`} − `req_pos` − `req_len`, modulo 2^31.
- R6: With `req_dir`=1, output lane i (byte i of `out_data`) carries input lane LANES−1−i. With `req_dir`=0 the lanes pass through unchanged.
- R7: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. Its result appears with `out_valid` high after that edge, one cycle of latency, and no result appears without an accepted request.
- R8: `req_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_addr` and `out_data` hold steady.
- R9: When a page write and a request for the same channel meet at one edge, the request uses the page value from before the write. The next request uses the new value.
- R10: With parameter `HIGH_EN`=0, high-bank writes are ignored, high-bank reads give zero, and addresses are formed with a high page of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Page byte write strobe |
| io_bank | input | 1 | 0 selects the low page bank, 1 selects the high page bank |
| io_off | input | 3 | Port offset, decoded to a channel |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read-back byte (combinational) |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Transfer request ready |
| req_chan | input | 2 | Request channel |
| req_cur | input | 16 | Channel current address |
| req_pos | input | 16 | Position within the block |
| req_len | input | 16 | Length used for downward transfers |
| req_dir | input | 1 | Direction bit from the channel mode (1 = downward) |
| req_data | input | 32 | Data lanes |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken |
| out_addr | output | 31 | Physical address |
| out_data | output | 32 | Data lanes, reversed for downward transfers |

## Verification
A page-byte write from the register port and a transfer request that reads the same channel's page can land on the same clock edge. The bench provokes this in two ways. Directed steps drive a low or high page write and a request for the matching channel at the same falling edge. Random steps draw writes and requests independently, so the two also meet often by chance. The result is judged against a model that forms the expected address from the page value held before the write, and only then applies the write. A later request then confirms that the new value has taken effect.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int CH_N = 4;
  localparam int CH_W = 2;

  typedef struct packed {
    logic            hit;
    logic [CH_W-1:0] ch;
  } slot_t;

  // Scrambled offset-to-channel map; offsets 0,4,5,6 are holes.
  function automatic slot_t map_offset(input logic [2:0] off);
    slot_t s;
    s.hit = 1'b1;
    s.ch  = '0;
    unique case (off)
      3'd1:    s.ch = 2'd2;
      3'd2:    s.ch = 2'd3;
      3'd3:    s.ch = 2'd1;
      3'd7:    s.ch = 2'd0;
      default: s.hit = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dpx_slot_decode.sv
module dpx_slot_decode
  import dpx_pkg::*;
(
  input  logic [2:0]      off,
  output logic            hit,
  output logic [CH_W-1:0] ch
);
  slot_t s;
  always_comb begin
    s   = map_offset(off);
    hit = s.hit;
    ch  = s.ch;
  end
endmodule

// File: rtl/dpx_page_bank.sv
module dpx_page_bank
  import dpx_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int SEL_W  = 8,
  parameter bit ENABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [PAGE_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [PAGE_W-1:0] rd_data,
  input  logic [CH_W-1:0]   xf_ch,
  output logic [SEL_W-1:0]  xf_page
);
  generate
    if (ENABLE) begin : g_on
      logic [PAGE_W-1:0] pages_q [CH_N];
      for (genvar c = 0; c < CH_N; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            pages_q[c] <= '0;
          else if (wr_en && (wr_ch == CH_W'(c)))
            pages_q[c] <= wr_data;
        end
      end
      assign rd_data = pages_q[rd_ch];
      assign xf_page = pages_q[xf_ch][SEL_W-1:0];
    end else begin : g_off
      logic unused_bank;
      assign unused_bank = ^{clk, rst_n, wr_en, wr_ch, wr_data, rd_ch, xf_ch};
      assign rd_data = '0;
      assign xf_page = '0;
    end
  endgenerate
endmodule

// File: rtl/dpx_lane_flip.sv
module dpx_lane_flip #(
  parameter int LANES = 4
) (
  input  logic                 flip,
  input  logic [LANES*8-1:0]   din,
  output logic [LANES*8-1:0]   dout
);
  logic [LANES*8-1:0] rev;
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign rev[i*8 +: 8] = din[(LANES-1-i)*8 +: 8];
    end
  endgenerate
  assign dout = flip ? rev : din;
endmodule

// File: rtl/dpx_addr_stage.sv
module dpx_addr_stage #(
  parameter int CUR_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int HI_USED = 7,
  parameter int LEN_W   = 16,
  parameter int LANES   = 4,
  localparam int ADDR_W = HI_USED + PAGE_W + CUR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [HI_USED-1:0] hi_page,
  input  logic [PAGE_W-1:0]  lo_page,
  input  logic [CUR_W-1:0]   cur,
  input  logic [CUR_W-1:0]   pos,
  input  logic [LEN_W-1:0]   len,
  input  logic               dir,
  input  logic [LANES*8-1:0] data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [LANES*8-1:0] out_data
);
  logic [ADDR_W-1:0]  base, pos_x, len_x, addr_d;
  logic [LANES*8-1:0] data_d;
  logic               take;

  assign base  = {hi_page, lo_page, cur};
  assign pos_x = ADDR_W'(pos);
  assign len_x = ADDR_W'(len);
  assign addr_d = dir ? (base - pos_x - len_x) : (base + pos_x);

  dpx_lane_flip #(.LANES(LANES)) u_flip (
    .flip (dir),
    .din  (data),
    .dout (data_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_addr <= addr_d;
        out_data <= data_d;
      end
    end
  end
endmodule

// File: rtl/dma_page_ext.sv
module dma_page_ext
  import dpx_pkg::*;
#(
  parameter int CUR_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int HI_USED = 7,
  parameter int LEN_W   = 16,
  parameter int LANES   = 4,
  parameter bit HIGH_EN = 1'b1,
  localparam int ADDR_W = HI_USED + PAGE_W + CUR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_wr,
  input  logic               io_bank,
  input  logic [2:0]         io_off,
  input  logic [PAGE_W-1:0]  io_wdata,
  output logic [PAGE_W-1:0]  io_rdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CH_W-1:0]    req_chan,
  input  logic [CUR_W-1:0]   req_cur,
  input  logic [CUR_W-1:0]   req_pos,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               req_dir,
  input  logic [LANES*8-1:0] req_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [LANES*8-1:0] out_data
);
  logic               slot_hit;
  logic [CH_W-1:0]    slot_ch;
  logic [PAGE_W-1:0]  lo_rd, hi_rd;
  logic [PAGE_W-1:0]  lo_xf;
  logic [HI_USED-1:0] hi_xf;

  dpx_slot_decode u_dec (
    .off (io_off),
    .hit (slot_hit),
    .ch  (slot_ch)
  );

  dpx_page_bank #(.PAGE_W(PAGE_W), .SEL_W(PAGE_W), .ENABLE(1'b1)) u_lo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (io_wr && slot_hit && !io_bank),
    .wr_ch   (slot_ch),
    .wr_data (io_wdata),
    .rd_ch   (slot_ch),
    .rd_data (lo_rd),
    .xf_ch   (req_chan),
    .xf_page (lo_xf)
  );

  dpx_page_bank #(.PAGE_W(PAGE_W), .SEL_W(HI_USED), .ENABLE(HIGH_EN)) u_hi (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (io_wr && slot_hit && io_bank),
    .wr_ch   (slot_ch),
    .wr_data (io_wdata),
    .rd_ch   (slot_ch),
    .rd_data (hi_rd),
    .xf_ch   (req_chan),
    .xf_page (hi_xf)
  );

  assign io_rdata = !slot_hit ? '0 : (io_bank ? hi_rd : lo_rd);

  dpx_addr_stage #(
    .CUR_W(CUR_W), .PAGE_W(PAGE_W), .HI_USED(HI_USED),
    .LEN_W(LEN_W), .LANES(LANES)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .hi_page   (hi_xf),
    .lo_page   (lo_xf),
    .cur       (req_cur),
    .pos       (req_pos),
    .len       (req_len),
    .dir       (req_dir),
    .data      (req_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_data  (out_data)
  );
endmodule

// File: rtl/dpx_checks.sv
module dpx_checks #(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 31,
  parameter int LANES  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         io_off,
  input logic [PAGE_W-1:0]  io_rdata,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_dir,
  input logic [LANES*8-1:0] req_data,
  input logic               out_valid,
  input logic               out_ready,
  input logic [ADDR_W-1:0]  out_addr,
  input logic [LANES*8-1:0] out_data
);
  logic hole;
  assign hole = (io_off == 3'd0) || (io_off == 3'd4) ||
                (io_off == 3'd5) || (io_off == 3'd6);

  logic [LANES*8-1:0] req_rev;
  for (genvar i = 0; i < LANES; i++) begin : g_rev
    assign req_rev[(LANES-1-i)*8 +: 8] = req_data[i*8 +: 8];
  end

  // R3
  hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hole |-> (io_rdata == '0));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));

  // R8
  stall_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !req_ready);

  // R7
  result_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(req_valid));

  // R6
  lane_reverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_dir) |=> (out_data == $past(req_rev)));
endmodule

bind dma_page_ext dpx_checks #(
  .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .LANES(LANES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_off    (io_off),
  .io_rdata  (io_rdata),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_dir   (req_dir),
  .req_data  (req_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_data  (out_data)
);

// File: tb/tb_dma_page_ext.sv
module tb_dma_page_ext;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_bank = 1'b0;
  logic [2:0]  io_off = 3'd0;
  logic [7:0]  io_wdata = 8'd0;
  logic [7:0]  rd_a, rd_b;
  logic        req_valid = 1'b0, out_ready = 1'b1, req_dir = 1'b0;
  logic [1:0]  req_chan = 2'd0;
  logic [15:0] req_cur = 16'd0, req_pos = 16'd0, req_len = 16'd0;
  logic [31:0] req_data = 32'd0;
  logic        rdy_a, rdy_b, ov_a, ov_b;
  logic [30:0] oa_a, oa_b;
  logic [31:0] od_a, od_b;

  always #4 clk = ~clk;

  dma_page_ext dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_bank(io_bank), .io_off(io_off),
    .io_wdata(io_wdata), .io_rdata(rd_a), .req_valid(req_valid), .req_ready(rdy_a),
    .req_chan(req_chan), .req_cur(req_cur), .req_pos(req_pos), .req_len(req_len),
    .req_dir(req_dir), .req_data(req_data), .out_valid(ov_a), .out_ready(out_ready),
    .out_addr(oa_a), .out_data(od_a));

  dma_page_ext #(.HIGH_EN(1'b0)) dut_nohi (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_bank(io_bank), .io_off(io_off),
    .io_wdata(io_wdata), .io_rdata(rd_b), .req_valid(req_valid), .req_ready(rdy_b),
    .req_chan(req_chan), .req_cur(req_cur), .req_pos(req_pos), .req_len(req_len),
    .req_dir(req_dir), .req_data(req_data), .out_valid(ov_b), .out_ready(out_ready),
    .out_addr(oa_b), .out_data(od_b));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] lo_m [4];
  logic [7:0] hi_m [4];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int off2ch(input logic [2:0] off);
    case (off)
      3'd7: return 0;
      3'd3: return 1;
      3'd1: return 2;
      3'd2: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [30:0] exp_addr(input logic [7:0] hi, input logic [7:0] lo,
      input logic [15:0] cur, input logic [15:0] pos, input logic [15:0] len, input logic dn);
    logic [30:0] b;
    b = {hi[6:0], lo, cur};
    return dn ? (b - {15'd0, pos} - {15'd0, len}) : (b + {15'd0, pos});
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] d, input logic dn);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = d[(3-i)*8 +: 8];
    return dn ? r : d;
  endfunction

  // drive inputs at negedge; model write applies at the following posedge
  task automatic io_write(input logic bank, input logic [2:0] off, input logic [7:0] v);
    @(negedge clk);
    io_wr = 1'b1; io_bank = bank; io_off = off; io_wdata = v;
    @(posedge clk);
    if (off2ch(off) >= 0) begin
      if (bank) hi_m[off2ch(off)] = v; else lo_m[off2ch(off)] = v;
    end
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_check(input logic bank, input logic [2:0] off, input string tag);
    logic [7:0] ea, eb;
    @(negedge clk);
    io_bank = bank; io_off = off;
    #1;
    if (off2ch(off) < 0) begin ea = 0; eb = 0; end
    else if (bank) begin ea = hi_m[off2ch(off)]; eb = 8'd0; end
    else begin ea = lo_m[off2ch(off)]; eb = ea; end
    check(rd_a == ea, tag, rd_a, ea);
    check(rd_b == eb, {tag, "/R10"}, rd_b, eb);
  endtask

  task automatic set_req(input logic [1:0] ch, input logic dn);
    req_chan = ch; req_dir = dn;
    req_cur = 16'($urandom); req_pos = 16'($urandom); req_len = 16'($urandom);
    req_data = $urandom;
  endtask

  task automatic check_out(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    logic [30:0] ea, eb;
    ea = exp_addr(hi, lo, req_cur, req_pos, req_len, req_dir);
    eb = exp_addr(8'd0, lo, req_cur, req_pos, req_len, req_dir);
    check(ov_a && ov_b, {tag, "/R7"}, {ov_a, ov_b}, 2'b11);
    check(oa_a == ea, tag, oa_a, ea);
    check(oa_b == eb, {tag, "/R10"}, oa_b, eb);
    check(od_a == exp_data(req_data, req_dir), {tag, "/R6"}, od_a, exp_data(req_data, req_dir));
  endtask

  // one request; optional same-edge page write (R9)
  task automatic do_req(input logic [1:0] ch, input logic dn, input bit wr,
                        input logic bank, input logic [2:0] off, input logic [7:0] v, input string tag);
    logic [7:0] hi_s, lo_s;
    @(negedge clk);
    out_ready = 1'b1;
    set_req(ch, dn);
    req_valid = 1'b1;
    io_wr = wr; io_bank = bank; io_off = off; io_wdata = v;
    hi_s = hi_m[ch]; lo_s = lo_m[ch];
    @(posedge clk);
    if (wr && off2ch(off) >= 0) begin
      if (bank) hi_m[off2ch(off)] = v; else lo_m[off2ch(off)] = v;
    end
    @(negedge clk);
    req_valid = 1'b0; io_wr = 1'b0;
    check_out(hi_s, lo_s, tag);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin lo_m[c] = 0; hi_m[c] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    check(!ov_a && !ov_b, "R1 out_valid", {ov_a, ov_b}, 0);
    for (int o = 0; o < 8; o++) begin
      io_check(1'b0, 3'(o), "R1 low");
      io_check(1'b1, 3'(o), "R1 high");
    end
    // R2 map, R4 bit7 dropped
    io_write(1'b0, 3'd7, 8'h11); io_write(1'b0, 3'd3, 8'h22);
    io_write(1'b0, 3'd1, 8'h33); io_write(1'b0, 3'd2, 8'h44);
    io_write(1'b1, 3'd7, 8'hF5); io_write(1'b1, 3'd2, 8'h80);
    for (int o = 0; o < 8; o++) begin
      io_check(1'b0, 3'(o), "R2 low");
      io_check(1'b1, 3'(o), "R2 high");
    end
    // R3 holes ignore writes
    io_write(1'b0, 3'd0, 8'hAA); io_write(1'b1, 3'd4, 8'hBB);
    io_write(1'b0, 3'd5, 8'hCC); io_write(1'b1, 3'd6, 8'hDD);
    for (int o = 0; o < 8; o++) begin
      io_check(1'b0, 3'(o), "R3 low");
      io_check(1'b1, 3'(o), "R3 high");
    end
    // R4 / R5 directed on each channel
    for (int c = 0; c < 4; c++) begin
      do_req(2'(c), 1'b0, 1'b0, 1'b0, 3'd0, 8'd0, "R4 up");
      do_req(2'(c), 1'b1, 1'b0, 1'b0, 3'd0, 8'd0, "R5 down");
    end
    // R5 wrap below zero
    io_write(1'b0, 3'd7, 8'h00); io_write(1'b1, 3'd7, 8'h00);
    @(negedge clk);
    do_req(2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 8'd0, "R5 wrap");
    // R9 same-edge write low and high
    do_req(2'd1, 1'b0, 1'b1, 1'b0, 3'd3, 8'h5A, "R9 low");
    do_req(2'd1, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0, "R9 after low");
    do_req(2'd3, 1'b1, 1'b1, 1'b1, 3'd2, 8'h6B, "R9 high");
    do_req(2'd3, 1'b1, 1'b0, 1'b0, 3'd0, 8'd0, "R9 after high");
    // R8 back-pressure
    begin
      logic [30:0] a1; logic [31:0] d1; logic [7:0] h2, l2;
      logic [15:0] c2, p2, n2; logic [31:0] dd2; logic dr2;
      @(negedge clk);
      out_ready = 1'b0; set_req(2'd2, 1'b0); req_valid = 1'b1;
      a1 = exp_addr(hi_m[2], lo_m[2], req_cur, req_pos, req_len, 1'b0);
      d1 = req_data;
      @(negedge clk);
      check(!rdy_a, "R8 ready low", rdy_a, 0);
      set_req(2'd0, 1'b1);
      h2 = hi_m[0]; l2 = lo_m[0]; c2 = req_cur; p2 = req_pos; n2 = req_len; dd2 = req_data; dr2 = req_dir;
      repeat (2) @(negedge clk);
      check(ov_a && oa_a == a1, "R8 hold addr", oa_a, a1);
      check(od_a == d1, "R8 hold data", od_a, d1);
      out_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(oa_a == exp_addr(h2, l2, c2, p2, n2, dr2), "R8 next", oa_a, exp_addr(h2, l2, c2, p2, n2, dr2));
      check(od_a == exp_data(dd2, dr2), "R8 next data R6", od_a, exp_data(dd2, dr2));
      @(negedge clk);
      check(!ov_a, "R7 drain", ov_a, 0);
    end
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [1:0] ch; logic dn, wr, bk; logic [2:0] of;
      ch = 2'($urandom); dn = 1'($urandom); wr = 1'($urandom);
      bk = 1'($urandom); of = 3'($urandom);
      if ($urandom % 3 == 0) ch = 2'(off2ch(of) < 0 ? ch : off2ch(of));
      do_req(ch, dn, wr, bk, of, 8'($urandom), "R9 random");
      if (k % 8 == 0) io_check(1'($urandom), 3'($urandom), "R2 random read");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule